// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block derives the SD card clock from a fixed reference clock of about 50 MHz. Host logic supplies a requested card frequency. The block finds the 8-bit divisor that gives the fastest card clock not above that request, and it records that divisor in the low byte of a 16-bit clock register. The upper byte of that register belongs to another divider on the chip, and the block never changes it. A counter output stage turns the divisor into the card clock.

Two overrides change the divisor in use. After a power-on event, the card runs at a fixed low post-power rate until one bulk transfer completes without error. Outside that phase, a platform slow request multiplies the divisor by a fixed ratio, with saturation. The clock is gated through a separate enable, so the stored divisor is never touched. The clock goes off after each request unless idle clocking is allowed or the slow-start phase is active. A power-off event always stops it.

Top module: `sd_clk_divider`

## Requirements
- R1: After a load of a non-zero frequency f, the base divisor becomes the smallest d in 0..255 with floor(REF/(d+1)) <= f, saturating at 255. The search takes at most 257 reference cycles, and the old divisor stays in use until it finishes.
- R2: A load of frequency zero turns the card clock enable off, unless idle clocking is enabled or slow start is active. In those two cases the enable is unchanged.
- R3: A power-on pulse sets the slow-start flag. While the flag is set, the effective divisor is min(REF/POST_HZ, 255), which is 50 by default, whatever the requested rate.
- R4: The slow-start flag clears only on a bulk-done pulse with the error input low. A bulk-done pulse with the error input high leaves it set.
- R5: With slow start inactive and the slow request high, the effective divisor is the base divisor times SLOW_RATIO (default 8), clamped to 255. During slow start, the slow request has no effect.
- R6: Clock register bits [7:0] hold the effective divisor, one cycle after it changes. Bits [15:8] change only through the upper-byte write port and keep their value otherwise.
- R7: Turning the card clock enable off leaves clock register bits [7:0] unchanged.
- R8: A request-end pulse turns the enable off, unless idle clocking is enabled or slow start is active.
- R9: A power-off pulse turns the enable off in the next cycle, whatever the idle-clock setting and any request-begin or load in the same cycle.
- R10: While running with divisor d, the card clock has a period P = d+1 reference cycles (P = 2 when d = 0). It is low for ceil(P/2) cycles, then high for floor(P/2) cycles.
- R11: A divisor change takes effect only at the start of a low phase. Every high phase therefore has the length of either the old divisor or the new one.
- R12: After reset, the clock register reads 0x00FF, the enable is low and the card clock is low. Once the enable drops, the card clock finishes its current period and then stays low.
- R13: A request-begin pulse, or a load of a non-zero frequency, turns the enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_hz | input | FREQ_W | Requested card frequency in Hz |
| freq_load | input | 1 | Pulse: apply freq_hz |
| slow_req | input | 1 | Platform slow-mode request (level) |
| idle_clk_en | input | 1 | Allow the clock to run while idle (level) |
| pwr_on | input | 1 | Pulse: card power applied |
| pwr_off | input | 1 | Pulse: card power removed |
| req_begin | input | 1 | Pulse: a card request starts |
| req_end | input | 1 | Pulse: a card request has completed |
| bulk_done | input | 1 | Pulse: a bulk transfer finished |
| bulk_err | input | 1 | Timeout or CRC error flag, valid with bulk_done |
| hi_we | input | 1 | Write strobe for the upper register byte |
| hi_wdata | input | 8 | Upper register byte value |
| clk_reg | output | 16 | Shared clock register: [15:8] other divider, [7:0] card divisor |
| card_clk_en | output | 1 | Clock enable into the divider |
| sd_clk | output | 1 | Card clock |

## Verification
The assertions assume that every event input is a single-cycle pulse and that bulk_err is meaningful only when bulk_done is high. They also assume that pwr_on and a bulk-done pulse do not arrive in the same cycle. The slow-start property further assumes that the flag was already set in the previous cycle. The stimulus drives each pulse for exactly one cycle, on the falling edge, and never combines power-on with a bulk-done pulse. After every frequency load it waits longer than the worst-case search time plus one full slowest period before it compares waveform lengths.

// File: rtl/sdcd_pkg.sv
package sdcd_pkg;
  localparam int unsigned DIV_W = 8;
  typedef logic [DIV_W-1:0] div_t;
  localparam div_t DIV_MAX = '1;
endpackage

// File: rtl/sdcd_div_search.sv
module sdcd_div_search
  import sdcd_pkg::*;
#(
  parameter int unsigned REF_HZ = 50_000_000,
  parameter int unsigned FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FREQ_W-1:0] freq,
  output div_t              div_o
);
  localparam int unsigned ACC_W = FREQ_W + DIV_W + 1;
  localparam logic [ACC_W-1:0] REF_V = ACC_W'(REF_HZ);

  logic             busy_q, busy_n;
  logic [ACC_W-1:0] acc_q, acc_n, incr;
  div_t             step_q, step_n, base_q, base_n;
  logic             hit;

  // acc_q holds (f+1)*(step+1); the first step where it exceeds REF is the answer
  always_comb begin
    incr   = ACC_W'(freq) + ACC_W'(1);
    hit    = acc_q > REF_V;
    busy_n = busy_q;
    acc_n  = acc_q;
    step_n = step_q;
    base_n = base_q;
    if (start) begin
      busy_n = 1'b1;
      acc_n  = incr;
      step_n = '0;
    end else if (busy_q) begin
      if (hit || step_q == DIV_MAX) begin
        busy_n = 1'b0;
        base_n = step_q;
      end else begin
        acc_n  = acc_q + incr;
        step_n = step_q + div_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      acc_q  <= '0;
      step_q <= '0;
      base_q <= DIV_MAX;
    end else begin
      busy_q <= busy_n;
      acc_q  <= acc_n;
      step_q <= step_n;
      base_q <= base_n;
    end
  end

  assign div_o = base_q;

  AST_SEARCH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> ($past(acc_q) > REF_V || base_q == DIV_MAX)); // R1

endmodule

// File: rtl/sdcd_policy.sv
module sdcd_policy
  import sdcd_pkg::*;
#(
  parameter int unsigned REF_HZ     = 50_000_000,
  parameter int unsigned POST_HZ    = 1_000_000,
  parameter int unsigned SLOW_RATIO = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_nz,
  input  logic        load_z,
  input  logic        slow_req,
  input  logic        idle_clk_en,
  input  logic        pwr_on,
  input  logic        pwr_off,
  input  logic        req_begin,
  input  logic        req_end,
  input  logic        bulk_done,
  input  logic        bulk_err,
  input  logic        hi_we,
  input  logic [7:0]  hi_wdata,
  input  div_t        base_div,
  output logic [15:0] clk_reg,
  output logic        clk_on
);
  localparam int unsigned POST_RAW = REF_HZ / ((POST_HZ == 0) ? 1 : POST_HZ);
  localparam div_t POST_DIV = (POST_RAW > ((1 << DIV_W) - 1)) ? DIV_MAX : div_t'(POST_RAW);

  logic       slow_q, slow_n;
  logic       on_q, on_n;
  logic [7:0] hi_q, hi_n;
  div_t       lo_q, lo_n;
  div_t       scaled_div, eff_div;

  generate
    if (SLOW_RATIO <= 1) begin : g_no_scale
      assign scaled_div = base_div;
    end else begin : g_scale
      localparam int unsigned RW = $clog2(SLOW_RATIO + 1);
      localparam int unsigned PW = DIV_W + RW;
      logic [PW-1:0] prod;
      assign prod       = PW'(base_div) * PW'(SLOW_RATIO);
      assign scaled_div = (prod > PW'(DIV_MAX)) ? DIV_MAX : prod[DIV_W-1:0];
    end
  endgenerate

  always_comb begin
    eff_div = slow_q ? POST_DIV : (slow_req ? scaled_div : base_div);

    slow_n = slow_q;
    if (pwr_on)                     slow_n = 1'b1;
    else if (bulk_done && !bulk_err) slow_n = 1'b0;

    on_n = on_q;
    if (pwr_off)
      on_n = 1'b0;
    else if (req_begin || load_nz)
      on_n = 1'b1;
    else if ((req_end || load_z) && !idle_clk_en && !slow_q)
      on_n = 1'b0;

    hi_n = hi_we ? hi_wdata : hi_q;
    lo_n = eff_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      on_q   <= 1'b0;
      hi_q   <= '0;
      lo_q   <= DIV_MAX;
    end else begin
      slow_q <= slow_n;
      on_q   <= on_n;
      hi_q   <= hi_n;
      lo_q   <= lo_n;
    end
  end

  assign clk_reg = {hi_q, lo_q};
  assign clk_on  = on_q;

  AST_SLOW_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> slow_q); // R3
  AST_SLOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_q && $past(slow_q)) |-> lo_q == POST_DIV); // R3
  AST_SLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_done && !bulk_err && !pwr_on) |=> !slow_q); // R4
  AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we |=> $stable(clk_reg[15:8])); // R6
  AST_PWROFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> !clk_on); // R9

endmodule

// File: rtl/sdcd_out_stage.sv
module sdcd_out_stage
  import sdcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_on,
  input  div_t div_in,
  output logic sd_clk
);
  localparam int unsigned CW = DIV_W + 1;

  function automatic logic [CW-1:0] per_len(input div_t d);
    logic [CW-1:0] p;
    p = {1'b0, d} + CW'(1);
    if (d == '0) p = CW'(2);
    return p;
  endfunction

  function automatic logic [CW-1:0] low_len(input logic [CW-1:0] p);
    return (p >> 1) + CW'(p[0]);
  endfunction

  logic [CW-1:0] cnt_q, cnt_n, per_c;
  div_t          act_q, act_n;
  logic          run_q, run_n;
  logic          clk_q, clk_n;

  always_comb begin
    per_c = per_len(act_q);
    if (!run_q) begin
      cnt_n = '0;
      act_n = div_in;
      run_n = clk_on;
    end else if (cnt_q == per_c - CW'(1)) begin
      cnt_n = '0;
      act_n = div_in;
      run_n = clk_on;
    end else begin
      cnt_n = cnt_q + CW'(1);
      act_n = act_q;
      run_n = 1'b1;
    end
    clk_n = run_n && (cnt_n >= low_len(per_len(act_n)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= DIV_MAX;
      run_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
      run_q <= run_n;
      clk_q <= clk_n;
    end
  end

  assign sd_clk = clk_q;

  AST_DIV_AT_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> cnt_q == '0); // R11

endmodule

// File: rtl/sd_clk_divider.sv
module sd_clk_divider
  import sdcd_pkg::*;
#(
  parameter int unsigned REF_HZ     = 50_000_000,
  parameter int unsigned POST_HZ    = 1_000_000,
  parameter int unsigned SLOW_RATIO = 8,
  parameter int unsigned FREQ_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREQ_W-1:0] freq_hz,
  input  logic              freq_load,
  input  logic              slow_req,
  input  logic              idle_clk_en,
  input  logic              pwr_on,
  input  logic              pwr_off,
  input  logic              req_begin,
  input  logic              req_end,
  input  logic              bulk_done,
  input  logic              bulk_err,
  input  logic              hi_we,
  input  logic [7:0]        hi_wdata,
  output logic [15:0]       clk_reg,
  output logic              card_clk_en,
  output logic              sd_clk
);
  logic load_nz, load_z;
  div_t base_div;

  assign load_nz = freq_load && (freq_hz != '0);
  assign load_z  = freq_load && (freq_hz == '0);

  sdcd_div_search #(.REF_HZ(REF_HZ), .FREQ_W(FREQ_W)) u_search (
    .clk(clk), .rst_n(rst_n), .start(load_nz), .freq(freq_hz), .div_o(base_div)
  );

  sdcd_policy #(.REF_HZ(REF_HZ), .POST_HZ(POST_HZ), .SLOW_RATIO(SLOW_RATIO)) u_policy (
    .clk(clk), .rst_n(rst_n), .load_nz(load_nz), .load_z(load_z),
    .slow_req(slow_req), .idle_clk_en(idle_clk_en), .pwr_on(pwr_on),
    .pwr_off(pwr_off), .req_begin(req_begin), .req_end(req_end),
    .bulk_done(bulk_done), .bulk_err(bulk_err), .hi_we(hi_we),
    .hi_wdata(hi_wdata), .base_div(base_div), .clk_reg(clk_reg),
    .clk_on(card_clk_en)
  );

  sdcd_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .clk_on(card_clk_en), .div_in(clk_reg[7:0]),
    .sd_clk(sd_clk)
  );

endmodule

// File: tb/sd_clk_divider_tb.sv
module sd_clk_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint REF = 50_000_000;

  logic        clk, rst_n;
  logic [31:0] freq_hz;
  logic        freq_load, slow_req, idle_clk_en, pwr_on, pwr_off;
  logic        req_begin, req_end, bulk_done, bulk_err, hi_we;
  logic [7:0]  hi_wdata;
  logic [15:0] clk_reg;
  logic        card_clk_en, sd_clk;

  sd_clk_divider dut_i (
    .clk(clk), .rst_n(rst_n), .freq_hz(freq_hz), .freq_load(freq_load),
    .slow_req(slow_req), .idle_clk_en(idle_clk_en), .pwr_on(pwr_on),
    .pwr_off(pwr_off), .req_begin(req_begin), .req_end(req_end),
    .bulk_done(bulk_done), .bulk_err(bulk_err), .hi_we(hi_we),
    .hi_wdata(hi_wdata), .clk_reg(clk_reg), .card_clk_en(card_clk_en),
    .sd_clk(sd_clk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  typedef struct { string tag; int exp_div; int exp_low; int exp_high; } item_t;
  item_t sbq[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_div(input longint f);
    longint d;
    d = REF / (f + 1);
    return (d > 255) ? 255 : int'(d);
  endfunction

  task automatic measure(output int lo, output int hi);
    int guard;
    guard = 0;
    while (sd_clk !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
    while (sd_clk !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    hi = 0;
    while (sd_clk === 1'b1 && guard < 3000) begin hi++; @(negedge clk); guard++; end
    lo = 0;
    while (sd_clk === 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
  endtask

  // monitor: pops expected items and compares the live register and waveform
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        int lo, hi;
        it = sbq[0];
        chk({it.tag, " divisor"}, int'(clk_reg[7:0]), it.exp_div);
        measure(lo, hi);
        measure(lo, hi);
        chk({it.tag, " R10 low"}, lo, it.exp_low);
        chk({it.tag, " R10 high"}, hi, it.exp_high);
        void'(sbq.pop_front());
      end
    end
  end

  // driver side: push an expected clock and wait until the monitor consumed it
  task automatic expect_clock(input string tag, input int d);
    item_t it;
    int p;
    p = (d == 0) ? 2 : d + 1;
    it.tag = tag; it.exp_div = d; it.exp_low = (p + 1) / 2; it.exp_high = p / 2;
    sbq.push_back(it);
    while (sbq.size() != 0) @(negedge clk);
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input longint f);
    freq_hz = 32'(f); freq_load = 1'b1;
    @(negedge clk); freq_load = 1'b0;
  endtask

  task automatic ev(input int which);
    case (which)
      0: pwr_on = 1'b1;
      1: pwr_off = 1'b1;
      2: req_begin = 1'b1;
      3: req_end = 1'b1;
      default: bulk_done = 1'b1;
    endcase
    @(negedge clk);
    pwr_on = 1'b0; pwr_off = 1'b0; req_begin = 1'b0; req_end = 1'b0; bulk_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; freq_hz = '0; freq_load = 0; slow_req = 0; idle_clk_en = 0;
    pwr_on = 0; pwr_off = 0; req_begin = 0; req_end = 0; bulk_done = 0;
    bulk_err = 0; hi_we = 0; hi_wdata = '0;
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    chk("R12 reset reg", int'(clk_reg), 16'h00FF);
    chk("R12 reset en", int'(card_clk_en), 0);
    chk("R12 reset sd_clk", int'(sd_clk), 0);

    hi_wdata = 8'hA5; hi_we = 1'b1; @(negedge clk); hi_we = 1'b0; hi_wdata = 8'h00;
    waitc(2);
    chk("R6 upper byte", int'(clk_reg[15:8]), 8'hA5);

    load(16_666_667); ev(2);
    chk("R13 enable on begin", int'(card_clk_en), 1);
    waitc(600);
    expect_clock("R1 16.67MHz", model_div(16_666_667));
    load(400_000); waitc(600);
    expect_clock("R1 400kHz", model_div(400_000));

    // R11: change 124 -> 255 while running; every high phase must be old or new
    load(1);
    for (int k = 0; k < 6; k++) begin
      int lo, hi;
      measure(lo, hi);
      chk("R11 high phase whole", int'(hi == 62 || hi == 128), 1);
    end
    waitc(600);
    expect_clock("R1 clamp", model_div(1));
    chk("R6 upper byte kept", int'(clk_reg[15:8]), 8'hA5);
    load(50_000_000); waitc(600);
    expect_clock("R10 div zero", model_div(50_000_000));

    slow_req = 1'b1;
    load(10_000_000); waitc(600);
    expect_clock("R5 scaled", model_div(10_000_000) * 8);
    load(1_000_000); waitc(600);
    expect_clock("R5 scaled clamp", 255);
    slow_req = 1'b0; waitc(3);
    chk("R5 slow off", int'(clk_reg[7:0]), 49);

    ev(3);
    chk("R8 end gates", int'(card_clk_en), 0);
    waitc(600);
    chk("R12 gated low", int'(sd_clk), 0);
    chk("R7 divisor kept", int'(clk_reg[7:0]), 49);

    ev(2); idle_clk_en = 1'b1; waitc(2);
    ev(3);
    chk("R8 idle keeps on", int'(card_clk_en), 1);
    load(0);
    chk("R2 zero idle keeps on", int'(card_clk_en), 1);
    chk("R7 zero keeps div", int'(clk_reg[7:0]), 49);
    idle_clk_en = 1'b0;
    load(0);
    chk("R2 zero stops", int'(card_clk_en), 0);

    ev(0); load(25_000_000); ev(2); waitc(600);
    expect_clock("R3 post-power div", 50);
    slow_req = 1'b1; waitc(3);
    chk("R5 ignored in slow start", int'(clk_reg[7:0]), 50);
    slow_req = 1'b0;
    load(0);
    chk("R2 slow start keeps on", int'(card_clk_en), 1);
    ev(3);
    chk("R8 slow start keeps on", int'(card_clk_en), 1);
    bulk_err = 1'b1; ev(4); bulk_err = 1'b0; waitc(3);
    chk("R4 error keeps slow", int'(clk_reg[7:0]), 50);
    ev(4); waitc(3);
    expect_clock("R4 cleared", model_div(25_000_000));

    idle_clk_en = 1'b1;
    pwr_off = 1'b1; req_begin = 1'b1; @(negedge clk);
    pwr_off = 1'b0; req_begin = 1'b0;
    chk("R9 power off", int'(card_clk_en), 0);
    waitc(20);
    chk("R9 clock low", int'(sd_clk), 0);

    finish_run();
  end
endmodule